// File: doc/BRIEF.md
# Mixed-Drive Bidirectional Port with PWM Alternate Output

This block is a five-bit general-purpose I/O port in which the bits do not share one pad style. The three low bits are open-drain: they can pull their pin low or let it go, and never push it high. The two upper bits have a weak internal pull-up. A bit holding 1 releases its pin, so the pin can also serve as an input. Each bit has an output latch, written from the internal bus by a one-cycle strobe. Software can read back either the latch contents or the live pin levels.

The top bit can be handed to a PWM generator in place of its latch. While the PWM alternate is selected, that bit drives its pad in push-pull from the PWM signal. When a low-power state has stopped the PWM clock domain, the bit is held strongly low so the pad does not float or freeze mid-pulse. The latch-driven bits keep their values through low-power states. Pad drive is given per pin as a strong-drive enable, a drive value and a weak pull-up enable. Analog pad behaviour is outside this block.

Top module: `mixed_io_port`

## Requirements
- R1: After reset every latch bit reads 1. No pad is strongly driven (padOe = 00000), and the weak pull-up is on only for bits 3 and 4 (padPullEn = 11000).
- R2: When wrEn is high at a rising clock edge, the latch takes wrData and rdLatch shows it after that edge. When wrEn is low, the latch keeps its value whatever wrData does.
- R3: rdPin equals padIn bit for bit at all times, whatever the latch and PWM settings are.
- R4: Bits 0 to 2 are open-drain. A latch 0 gives padOe=1 with padOut=0, and a latch 1 gives padOe=0. These bits never have padOut=1 or padPullEn=1.
- R5: Bit 3, and bit 4 while the PWM alternate is off, drive strongly low (padOe=1, padOut=0, padPullEn=0) for a latch 0. For a latch 1 they release (padOe=0) with padPullEn=1.
- R6: While pwmEnable is high and lowPower is low, bit 4 drives push-pull: padOe[4]=1, padOut[4]=pwmIn and padPullEn[4]=0. Latch bit 4 has no effect on the pad, and rdLatch still returns it.
- R7: While pwmEnable and lowPower are both high, bit 4 is driven strongly low (padOe[4]=1, padOut[4]=0). The lowPower input has no effect on any pin driven from its latch.
- R8: While pwmEnable is low, pwmIn has no effect on any pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Latch write strobe |
| wrData | input | 5 | Data written to the latch |
| padIn | input | 5 | Sensed pin levels |
| pwmIn | input | 1 | PWM generator output |
| pwmEnable | input | 1 | Selects PWM as the bit-4 source |
| lowPower | input | 1 | PWM clock domain is stopped |
| rdLatch | output | 5 | Latch read-back |
| rdPin | output | 5 | Pin read-back |
| padOe | output | 5 | Strong-drive enable per pin |
| padOut | output | 5 | Strong-drive value per pin |
| padPullEn | output | 5 | Weak pull-up enable per pin |

## Verification
The bench checks that the open-drain bits never drive high. A design that treated every bit alike would show padOut=1 or a pull-up on bits 0 to 2. It toggles pwmIn while the alternate is off, which exposes a mux that leaks the PWM signal onto bit 4. It also selects the alternate with latch bit 4 at 0 and at 1, to catch a design that ANDs or ORs the latch into the PWM path. With lowPower set, it checks that bit 4 is forced low only when PWM is selected, and that the latch bits are left as they were. A design that gated the whole port on lowPower, or let a stalled PWM level through, fails there.

// File: rtl/mixed_io_pkg.sv
package mixed_io_pkg;
  typedef struct packed {
    logic latchLoad;   // capture wrData this edge
    logic altSel;      // alternate bit sourced from PWM
    logic altHoldLow;  // PWM domain stopped: hold alternate bit low
  } ioStrobes_t;
endpackage

// File: rtl/mixed_io_ctrl.sv
module mixed_io_ctrl
  import mixed_io_pkg::*;
(
  input  logic       wrEn,
  input  logic       pwmEnable,
  input  logic       lowPower,
  output ioStrobes_t strobes
);
  always_comb begin
    strobes.latchLoad  = wrEn;
    strobes.altSel     = pwmEnable;
    strobes.altHoldLow = pwmEnable & lowPower;
  end
endmodule

// File: rtl/mixed_io_dp.sv
module mixed_io_dp
  import mixed_io_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] PULL_MASK = 5'b11000,
  parameter int ALT_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ioStrobes_t       strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  input  logic             pwmIn,
  output logic [WIDTH-1:0] rdLatch,
  output logic [WIDTH-1:0] rdPin,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullEn
);
  logic [WIDTH-1:0] portLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  portLatch <= '1;
    else if (strobes.latchLoad) portLatch <= wrData;
  end

  assign rdLatch = portLatch;
  assign rdPin   = padIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam bit HAS_PULL = PULL_MASK[i];
    if (i == ALT_BIT) begin : g_alt
      logic altVal;
      assign altVal = strobes.altHoldLow ? 1'b0 : pwmIn;
      always_comb begin
        if (strobes.altSel) begin
          padOe[i]     = 1'b1;
          padOut[i]    = altVal;
          padPullEn[i] = 1'b0;
        end else begin
          padOe[i]     = ~portLatch[i];
          padOut[i]    = 1'b0;
          padPullEn[i] = HAS_PULL & portLatch[i];
        end
      end
    end else begin : g_gpio
      always_comb begin
        padOe[i]     = ~portLatch[i];
        padOut[i]    = 1'b0;
        padPullEn[i] = HAS_PULL & portLatch[i];
      end
    end
  end
endmodule

// File: rtl/mixed_io_port.sv
module mixed_io_port
  import mixed_io_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] PULL_MASK = 5'b11000,
  parameter int ALT_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  input  logic             pwmIn,
  input  logic             pwmEnable,
  input  logic             lowPower,
  output logic [WIDTH-1:0] rdLatch,
  output logic [WIDTH-1:0] rdPin,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullEn
);
  ioStrobes_t strobes;

  mixed_io_ctrl u_ctrl (
    .wrEn(wrEn), .pwmEnable(pwmEnable), .lowPower(lowPower), .strobes(strobes)
  );

  mixed_io_dp #(.WIDTH(WIDTH), .PULL_MASK(PULL_MASK), .ALT_BIT(ALT_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .padIn(padIn),
    .pwmIn(pwmIn), .rdLatch(rdLatch), .rdPin(rdPin), .padOe(padOe),
    .padOut(padOut), .padPullEn(padPullEn)
  );
endmodule

// File: rtl/mixed_io_port_chk.sv
module mixed_io_port_chk #(
  parameter int WIDTH = 5,
  parameter logic [WIDTH-1:0] PULL_MASK = 5'b11000,
  parameter int ALT_BIT = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [WIDTH-1:0] wrData,
  input logic [WIDTH-1:0] padIn,
  input logic             pwmIn,
  input logic             pwmEnable,
  input logic             lowPower,
  input logic [WIDTH-1:0] rdLatch,
  input logic [WIDTH-1:0] rdPin,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padPullEn
);
  localparam logic [WIDTH-1:0] OD_MASK = ~PULL_MASK;

  assert_reset_ones_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> rdLatch == '1);

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdLatch == $past(wrData));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdLatch));

  assert_pin_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdPin == padIn);

  assert_open_drain_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut | padPullEn) & OD_MASK) == '0);

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPullEn) == '0);

  assert_pwm_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && !lowPower) |-> (padOe[ALT_BIT] && padOut[ALT_BIT] == pwmIn));

  assert_pwm_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && lowPower) |-> (padOe[ALT_BIT] && !padOut[ALT_BIT]));
endmodule

bind mixed_io_port mixed_io_port_chk #(.WIDTH(WIDTH), .PULL_MASK(PULL_MASK), .ALT_BIT(ALT_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .padIn(padIn),
  .pwmIn(pwmIn), .pwmEnable(pwmEnable), .lowPower(lowPower), .rdLatch(rdLatch),
  .rdPin(rdPin), .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
);

// File: tb/mixed_io_port_bench.sv
module mixed_io_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrData = '0;
  logic [4:0] padIn = '0;
  logic       pwmIn = 1'b0;
  logic       pwmEnable = 1'b0;
  logic       lowPower = 1'b0;
  logic [4:0] rdLatch, rdPin, padOe, padOut, padPullEn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mixed_io_port u_mixed_io_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .padIn(padIn),
    .pwmIn(pwmIn), .pwmEnable(pwmEnable), .lowPower(lowPower), .rdLatch(rdLatch),
    .rdPin(rdPin), .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );

  // {data, pwmEnable, pwmIn, lowPower, expOe, expOut, expPull, reqTag}
  typedef struct packed {
    logic [4:0] data;
    logic       pe;
    logic       pin;
    logic       lp;
    logic [4:0] oe;
    logic [4:0] out;
    logic [4:0] pull;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{5'b11111, 1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, 5'b11000, 8'd5},
    '{5'b00000, 1'b0, 1'b0, 1'b0, 5'b11111, 5'b00000, 5'b00000, 8'd4},
    '{5'b10101, 1'b0, 1'b0, 1'b0, 5'b01010, 5'b00000, 5'b10000, 8'd4},
    '{5'b01010, 1'b0, 1'b1, 1'b0, 5'b10101, 5'b00000, 5'b01000, 8'd8},
    '{5'b11111, 1'b1, 1'b1, 1'b0, 5'b10000, 5'b10000, 5'b01000, 8'd6},
    '{5'b11111, 1'b1, 1'b0, 1'b0, 5'b10000, 5'b00000, 5'b01000, 8'd6},
    '{5'b00111, 1'b1, 1'b1, 1'b1, 5'b11000, 5'b00000, 5'b00000, 8'd7},
    '{5'b01111, 1'b0, 1'b1, 1'b1, 5'b10000, 5'b00000, 5'b01000, 8'd7},
    '{5'b00001, 1'b1, 1'b1, 1'b0, 5'b11110, 5'b10000, 5'b00000, 8'd6}
  };

  task automatic check(input string req, input string what, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic writeLatch(input logic [4:0] d);
    @(negedge clk);
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "rdLatch", rdLatch, 5'b11111);
    check("R1", "padOe", padOe, 5'b00000);
    check("R1", "padPullEn", padPullEn, 5'b11000);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      pwmEnable = VECS[v].pe;
      pwmIn     = VECS[v].pin;
      lowPower  = VECS[v].lp;
      writeLatch(VECS[v].data);
      check($sformatf("R%0d", VECS[v].req), "padOe", padOe, VECS[v].oe);
      check($sformatf("R%0d", VECS[v].req), "padOut", padOut, VECS[v].out);
      check($sformatf("R%0d", VECS[v].req), "padPullEn", padPullEn, VECS[v].pull);
      check("R2", "rdLatch", rdLatch, VECS[v].data);
    end

    // R8: toggling pwmIn with alternate off leaves pads unchanged
    pwmEnable = 1'b0; lowPower = 1'b0;
    writeLatch(5'b01100);
    pwmIn = 1'b1;
    @(negedge clk);
    check("R8", "padOe", padOe, 5'b10011);
    check("R8", "padOut", padOut, 5'b00000);
    pwmIn = 1'b0;
    @(negedge clk);
    check("R8", "padOe", padOe, 5'b10011);

    // R2: data change without strobe is ignored
    wrData = 5'b10011;
    repeat (2) @(negedge clk);
    check("R2", "rdLatch hold", rdLatch, 5'b01100);
    check("R2", "padOe hold", padOe, 5'b10011);

    // R3: pin read follows padIn independent of latch
    padIn = 5'b10110;
    #1;
    check("R3", "rdPin", rdPin, 5'b10110);
    padIn = 5'b01001;
    #1;
    check("R3", "rdPin", rdPin, 5'b01001);

    // R6: latch bit 4 read back while PWM owns the pad
    pwmEnable = 1'b1; pwmIn = 1'b1;
    writeLatch(5'b00000);
    check("R6", "rdLatch", rdLatch, 5'b00000);
    check("R6", "padOut", padOut, 5'b10000);
    // R7: low power forces bit 4 low, latch bits untouched
    lowPower = 1'b1;
    #1;
    check("R7", "padOut", padOut, 5'b00000);
    check("R7", "padOe", padOe, 5'b11111);

    // R1: reset mid-run restores the reset state
    pwmEnable = 1'b0; lowPower = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1", "rdLatch after reset", rdLatch, 5'b11111);
    check("R1", "padPullEn after reset", padPullEn, 5'b11000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule